// File: doc/BRIEF.md
# Extended I/O interrupt router

This block collects a wide vector of external interrupt lines and steers each one to a chosen CPU core and to one of several interrupt pins on that core. Lines are handled in groups of 32. Each line has an enable bit and a core selection of its own. Each group shares one pin selection. When a line rises while it is enabled, the router latches the event into a status register that belongs to the selected core. A core output pin stays high while any enabled status bit routed to it is set. Software clears status bits through a write-one-to-clear register.

A line that rises while it is disabled is not dropped. It is parked in an internal pending store and is delivered in the same cycle that software enables it. A line that is already latched follows its group's pin selection. Rewriting the pin map therefore moves the active request to the new pin at once. Clearing an enable bit silences the line's output but leaves its status bit set.

Software uses a word-wide register port with a single-cycle write strobe and combinational read data. Only the low 16 address bits are decoded. The register map is fixed:
- 0x0100: enable words.
- 0x0400: pin map.
- 0x0800: core map.
- 0x4000: status registers, with a stride of 0x100 per core.

Top module: `xir_router`

## Requirements
- R1: Line L is held in status word L/32, bit L%32, of its core. That word reads at 0x4000 + core*0x100 + (L/32)*4. Enable word w at 0x0100 + 4w holds lines 32w..32w+31, with line 32w+b in bit b.
- R2: A line that rises while its enable bit is clear sets no status bit in any core. It is remembered as pending. A later 0-to-1 write of its enable bit delivers it exactly once. Writing the enable bit 0 and then 1 without a rise in between delivers nothing.
- R3: A rise on a line whose enable bit is set after the current cycle's writes sets the line's status bit in the core chosen by the core map. The bit is visible on the clock edge that samples the rise. This includes a rise that arrives in the same cycle as the enable write.
- R4: A write that takes enable bits from 0 to 1 delivers every pending line among them in that one cycle and clears their pending state. Rewriting an enable bit that is already 1 delivers nothing.
- R5: The pin map holds one byte per group of 32 lines. Word 0x0400 + 4k holds groups 4k..4k+3, with group 4k+j in byte j. The pin number is the low 3 bits of the byte. Those bits read back and the upper bits read as 0. Output bit core*8 + pin is the selected core/pin.
- R6: After a pin-map write, a latched and enabled line drives its new pin instead of the old one. The change is visible from the write's clock edge onward.
- R7: Clearing a line's enable bit removes its contribution to the output pins. Its status bit still reads as 1. Setting the enable bit again restores the output without a new rise.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A pin drops once no enabled status bit routed to it remains set.
- R9: If a status bit is cleared and its line rises, enabled, in the same cycle, the bit ends up set.
- R10: Address bits 31..16 are ignored for both reads and writes.
- R11: Reset clears all enable, pending, pin-map, core-map and status state. While reset is held, all output pins are low.
- R12: The core map holds one byte per line. Line L is in word 0x0800 + 4*(L/4), byte L%4. The core number is the low 2 bits of the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | 256 | External interrupt lines, one bit per line |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 32 | Register byte address; only bits 15..0 are decoded |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_out | output | 32 | Core interrupt pins, bit core*8 + pin |

## Verification
Two pairs of functions can act on the same line in one cycle.

The first pair is a rise and an enable write. The bench raises a disabled line in the same cycle that it enables that line's word. The status bit must be set at the next read, and no pending state may remain. This is judged by clearing the status, toggling the enable bit and confirming that nothing is delivered again.

The second pair is a rise and a write-one-to-clear. The bench drives both on one latched bit in the same cycle and expects the bit to stay set.

// File: rtl/xir_pkg.sv
package xir_pkg;
  localparam logic [15:0] EN_BASE   = 16'h0100;
  localparam logic [15:0] PIN_BASE  = 16'h0400;
  localparam logic [15:0] CMAP_BASE = 16'h0800;
  localparam logic [15:0] STAT_BASE = 16'h4000;
  localparam int          STAT_STRIDE = 256;

  typedef enum logic [2:0] {RG_NONE, RG_EN, RG_PIN, RG_CMAP, RG_STAT} region_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xir_maps.sv
module xir_maps #(
  parameter int N_LINES = 256,
  parameter int PIN_W   = 3,
  parameter int CORE_W  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic                              pin_sel,
  input  logic                              cmap_sel,
  input  logic [13:0]                       widx,
  input  logic [31:0]                       wdata,
  output logic [N_LINES/32-1:0][PIN_W-1:0]  pin_map,
  output logic [N_LINES-1:0][CORE_W-1:0]    core_map,
  output logic [31:0]                       rdata
);
  localparam int N_GROUPS = N_LINES / 32;

  logic [N_GROUPS-1:0][PIN_W-1:0]  pin_q, pin_d;
  logic [N_GROUPS-1:0]             pin_we;
  logic [N_LINES-1:0][CORE_W-1:0]  cmap_q, cmap_d;
  logic [N_LINES-1:0]              cmap_we;
  logic                            unused_wdata;

  assign unused_wdata = ^wdata;

  // next state: each byte lane of a word feeds one entry
  always_comb begin
    for (int g = 0; g < N_GROUPS; g++) begin
      pin_we[g] = bus_wr && pin_sel && (widx == 14'(g / 4));
      pin_d[g]  = wdata[8*(g%4) +: PIN_W];
    end
    for (int l = 0; l < N_LINES; l++) begin
      cmap_we[l] = bus_wr && cmap_sel && (widx == 14'(l / 4));
      cmap_d[l]  = wdata[8*(l%4) +: CORE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      cmap_q <= '0;
    end else begin
      for (int g = 0; g < N_GROUPS; g++)
        if (pin_we[g]) pin_q[g] <= pin_d[g];
      for (int l = 0; l < N_LINES; l++)
        if (cmap_we[l]) cmap_q[l] <= cmap_d[l];
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < N_GROUPS; g++)
      if (pin_sel && widx == 14'(g / 4)) rdata[8*(g%4) +: 8] = 8'(pin_q[g]);
    for (int l = 0; l < N_LINES; l++)
      if (cmap_sel && widx == 14'(l / 4)) rdata[8*(l%4) +: 8] = 8'(cmap_q[l]);
  end

  assign pin_map  = pin_q;
  assign core_map = cmap_q;
endmodule

// File: rtl/xir_event.sv
module xir_event #(
  parameter int N_LINES = 256,
  parameter int N_CORES = 4,
  parameter int CORE_W  = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_LINES-1:0]               irq_in,
  input  logic                             bus_wr,
  input  logic                             en_sel,
  input  logic                             st_sel,
  input  logic [13:0]                      widx,
  input  logic [7:0]                       st_core,
  input  logic [5:0]                       st_word,
  input  logic [31:0]                      wdata,
  input  logic [N_LINES-1:0][CORE_W-1:0]   core_map,
  output logic [N_LINES-1:0]               enable_o,
  output logic [N_CORES-1:0][N_LINES-1:0]  status_o,
  output logic [31:0]                      rdata
);
  localparam int N_WORDS = N_LINES / 32;

  logic [N_LINES-1:0] irq_q, enable_q, enable_d, pend_q, pend_d;
  logic [N_LINES-1:0] rise, newly, deliver, st_any;
  logic [N_CORES-1:0][N_LINES-1:0] stat_q, stat_d, clr_mask, route;
  logic en_ce, st_wr, pend_ce, st_ce;

  always_comb begin
    en_ce = bus_wr && en_sel;
    st_wr = bus_wr && st_sel;
    rise  = irq_in & ~irq_q;
    enable_d = enable_q;
    for (int w = 0; w < N_WORDS; w++)
      if (en_ce && widx == 14'(w)) enable_d[32*w +: 32] = wdata;
    // arrivals are judged against the post-write enable value
    newly   = enable_d & ~enable_q;
    deliver = (rise & enable_d) | (newly & pend_q);
    pend_d  = (pend_q | rise) & ~enable_d;
    for (int c = 0; c < N_CORES; c++) begin
      clr_mask[c] = '0;
      for (int w = 0; w < N_WORDS; w++)
        if (st_wr && st_core == 8'(c) && st_word == 6'(w))
          clr_mask[c][32*w +: 32] = wdata;
      for (int l = 0; l < N_LINES; l++)
        route[c][l] = (core_map[l] == CORE_W'(c));
      // a new delivery wins over a same-cycle clear
      stat_d[c] = (stat_q[c] & ~clr_mask[c]) | (deliver & route[c]);
    end
    pend_ce = en_ce || (|rise);
    st_ce   = st_wr || (|deliver);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= '0;
      enable_q <= '0;
      pend_q   <= '0;
      stat_q   <= '0;
    end else begin
      irq_q <= irq_in;
      if (en_ce)   enable_q <= enable_d;
      if (pend_ce) pend_q   <= pend_d;
      if (st_ce)   stat_q   <= stat_d;
    end
  end

  always_comb begin
    rdata  = '0;
    st_any = '0;
    for (int w = 0; w < N_WORDS; w++)
      if (en_sel && widx == 14'(w)) rdata = enable_q[32*w +: 32];
    for (int c = 0; c < N_CORES; c++) begin
      st_any = st_any | stat_q[c];
      for (int w = 0; w < N_WORDS; w++)
        if (st_sel && st_core == 8'(c) && st_word == 6'(w))
          rdata = stat_q[c][32*w +: 32];
    end
  end

  assign enable_o = enable_q;
  assign status_o = stat_q;

  // R2: pending state exists only for disabled lines
  p_pend_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & enable_q) == '0));
  // R2: pending bits appear only after a rise
  p_pend_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));
  // R3: a status bit appears only from a rise or a pending line
  p_set_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_any & ~$past(st_any) & ~$past(rise | pend_q)) == '0));
  // R8: a write-one-to-clear with no arrival leaves the bits clear
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && rise == '0) |=> ((stat_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/xir_fanout.sv
module xir_fanout #(
  parameter int N_LINES = 256,
  parameter int N_CORES = 4,
  parameter int N_PINS  = 8,
  parameter int PIN_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_LINES-1:0]               enable,
  input  logic [N_CORES-1:0][N_LINES-1:0]  status,
  input  logic [N_LINES/32-1:0][PIN_W-1:0] pin_map,
  output logic [N_CORES*N_PINS-1:0]        irq_out
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      logic [N_LINES-1:0] hit;
      always_comb begin
        for (int l = 0; l < N_LINES; l++)
          hit[l] = status[c][l] & enable[l] & (pin_map[l/32] == PIN_W'(p));
      end
      assign irq_out[c*N_PINS+p] = |hit;

      // R7: a pin is high only with an enabled status bit in its core
      p_out_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[c*N_PINS+p] |-> ((status[c] & enable) != '0));
    end
  end
endmodule

// File: rtl/xir_router.sv
module xir_router
  import xir_pkg::*;
#(
  parameter int N_LINES = 256,
  parameter int N_CORES = 4,
  parameter int N_PINS  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         irq_in,
  input  logic                       bus_wr,
  input  logic [31:0]                bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [N_CORES*N_PINS-1:0]  irq_out
);
  localparam int N_WORDS   = N_LINES / 32;
  localparam int PIN_W     = idx_w(N_PINS);
  localparam int CORE_W    = idx_w(N_CORES);
  localparam int PIN_BYTES = ((N_WORDS + 3) / 4) * 4;

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic [15:0] a16, off;
  region_e     rg;
  logic        unused_addr;
  logic [31:0] ev_rdata, map_rdata;
  logic [N_LINES-1:0]               enable;
  logic [N_CORES-1:0][N_LINES-1:0]  status;
  logic [N_WORDS-1:0][PIN_W-1:0]    pin_map;
  logic [N_LINES-1:0][CORE_W-1:0]   core_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // region decode on the low half of the address only
  always_comb begin
    a16 = bus_addr[15:0];
    rg  = RG_NONE;
    off = '0;
    if (a16 >= EN_BASE && a16 < EN_BASE + 16'(N_WORDS * 4)) begin
      rg = RG_EN;   off = a16 - EN_BASE;
    end else if (a16 >= PIN_BASE && a16 < PIN_BASE + 16'(PIN_BYTES)) begin
      rg = RG_PIN;  off = a16 - PIN_BASE;
    end else if (a16 >= CMAP_BASE && a16 < CMAP_BASE + 16'(N_LINES)) begin
      rg = RG_CMAP; off = a16 - CMAP_BASE;
    end else if (a16 >= STAT_BASE && a16 < STAT_BASE + 16'(N_CORES * STAT_STRIDE)) begin
      rg = RG_STAT; off = a16 - STAT_BASE;
    end
  end
  assign unused_addr = ^{bus_addr[31:16], off[1:0]};

  xir_maps #(.N_LINES(N_LINES), .PIN_W(PIN_W), .CORE_W(CORE_W)) u_maps (
    .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr),
    .pin_sel(rg == RG_PIN), .cmap_sel(rg == RG_CMAP),
    .widx(off[15:2]), .wdata(bus_wdata),
    .pin_map(pin_map), .core_map(core_map), .rdata(map_rdata)
  );

  xir_event #(.N_LINES(N_LINES), .N_CORES(N_CORES), .CORE_W(CORE_W)) u_event (
    .clk(clk), .rst_n(rst_int_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .en_sel(rg == RG_EN), .st_sel(rg == RG_STAT),
    .widx(off[15:2]), .st_core(off[15:8]), .st_word(off[7:2]),
    .wdata(bus_wdata), .core_map(core_map),
    .enable_o(enable), .status_o(status), .rdata(ev_rdata)
  );

  xir_fanout #(.N_LINES(N_LINES), .N_CORES(N_CORES), .N_PINS(N_PINS), .PIN_W(PIN_W)) u_fanout (
    .clk(clk), .rst_n(rst_int_n), .enable(enable), .status(status),
    .pin_map(pin_map), .irq_out(irq_out)
  );

  assign bus_rdata = ev_rdata | map_rdata;
endmodule

// File: tb/tb_xir_router.sv
module tb_xir_router;
  localparam int CLK_PERIOD = 10;
  localparam int N_LINES = 256;
  localparam int N_CORES = 4;
  localparam int N_PINS  = 8;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PULSE = 2'd2, OP_OUT = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] data;   // write data, expected value, or line number
    logic [3:0]  req;
  } vec_t;

  localparam int N_VEC = 44;
  localparam vec_t VECS [N_VEC] = '{
    '{OP_RD,    32'h0000_4000, 32'h0000_0000, 4'd11}, // R11 status clear
    '{OP_OUT,   32'h0,         32'h0000_0000, 4'd11}, // R11 pins low
    '{OP_RD,    32'h0000_0100, 32'h0000_0000, 4'd11}, // R11 enable clear
    '{OP_RD,    32'h0000_0400, 32'h0000_0000, 4'd11}, // R11 pin map clear
    '{OP_PULSE, 32'h0,         32'd5,         4'd2},  // R2 rise while disabled
    '{OP_RD,    32'h0000_4000, 32'h0000_0000, 4'd2},
    '{OP_OUT,   32'h0,         32'h0000_0000, 4'd2},
    '{OP_WR,    32'h0000_0804, 32'h0000_0200, 4'd12}, // R12 line 5 -> core 2
    '{OP_RD,    32'h0000_0804, 32'h0000_0200, 4'd12},
    '{OP_WR,    32'h0000_0400, 32'h0000_0603, 4'd5},  // R5 grp0 pin3, grp1 pin6
    '{OP_RD,    32'h0000_0400, 32'h0000_0603, 4'd5},
    '{OP_WR,    32'h0000_0100, 32'h0000_0020, 4'd4},  // R4 enable pending line 5
    '{OP_RD,    32'h0000_4200, 32'h0000_0020, 4'd4},
    '{OP_RD,    32'h0000_4000, 32'h0000_0000, 4'd4},
    '{OP_OUT,   32'h0,         32'h0008_0000, 4'd4},
    '{OP_WR,    32'h0000_0104, 32'h0000_0100, 4'd3},  // R3 enable line 40
    '{OP_PULSE, 32'h0,         32'd40,        4'd3},
    '{OP_RD,    32'h0000_4004, 32'h0000_0100, 4'd3},
    '{OP_OUT,   32'h0,         32'h0008_0040, 4'd3},
    '{OP_WR,    32'h0000_4200, 32'h0000_0020, 4'd8},  // R8 clear line 5
    '{OP_RD,    32'h0000_4200, 32'h0000_0000, 4'd8},
    '{OP_OUT,   32'h0,         32'h0000_0040, 4'd8},
    '{OP_WR,    32'h0000_0100, 32'h0000_0020, 4'd4},  // R4 rewrite, no redelivery
    '{OP_RD,    32'h0000_4200, 32'h0000_0000, 4'd4},
    '{OP_WR,    32'h0000_0400, 32'h0000_0203, 4'd6},  // R6 grp1 to pin 2
    '{OP_OUT,   32'h0,         32'h0000_0004, 4'd6},
    '{OP_WR,    32'h0000_0104, 32'h0000_0000, 4'd7},  // R7 disable line 40
    '{OP_OUT,   32'h0,         32'h0000_0000, 4'd7},
    '{OP_RD,    32'h0000_4004, 32'h0000_0100, 4'd7},
    '{OP_WR,    32'h0000_0104, 32'h0000_0100, 4'd7},
    '{OP_OUT,   32'h0,         32'h0000_0004, 4'd7},
    '{OP_RD,    32'hABCD_4004, 32'h0000_0100, 4'd10}, // R10 high bits ignored
    '{OP_WR,    32'h7777_4004, 32'h0000_0100, 4'd10},
    '{OP_OUT,   32'h0,         32'h0000_0000, 4'd10},
    '{OP_WR,    32'h0000_011C, 32'h8000_0000, 4'd1},  // R1 line 255
    '{OP_WR,    32'h0000_08FC, 32'h0300_0000, 4'd1},
    '{OP_PULSE, 32'h0,         32'd255,       4'd1},
    '{OP_RD,    32'h0000_431C, 32'h8000_0000, 4'd1},
    '{OP_RD,    32'h0000_401C, 32'h0000_0000, 4'd1},
    '{OP_OUT,   32'h0,         32'h0100_0000, 4'd1},
    '{OP_WR,    32'h0000_0404, 32'hFD00_0000, 4'd5},  // R5 upper byte bits dropped
    '{OP_RD,    32'h0000_0404, 32'h0500_0000, 4'd5},
    '{OP_OUT,   32'h0,         32'h2000_0000, 4'd5},
    '{OP_RD,    32'h0000_08FC, 32'h0300_0000, 4'd12}  // R12 byte lane 3
  };

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [N_LINES-1:0]        irq_in = '0;
  logic                      bus_wr = 1'b0;
  logic [31:0]               bus_addr = '0;
  logic [31:0]               bus_wdata = '0;
  logic [31:0]               bus_rdata;
  logic [N_CORES*N_PINS-1:0] irq_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xir_router #(.N_LINES(N_LINES), .N_CORES(N_CORES), .N_PINS(N_PINS)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    irq_in[line] = 1'b1;
    @(negedge clk);
    irq_in[line] = 1'b0;
  endtask

  task automatic read_chk(input int req, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, "read", bus_rdata, exp);
  endtask

  task automatic out_chk(input int req, input logic [31:0] exp);
    @(negedge clk);
    #1;
    check(req, "irq_out", irq_out, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      case (VECS[i].op)
        OP_WR:    bus_write(VECS[i].addr, VECS[i].data);
        OP_RD:    read_chk(int'(VECS[i].req), VECS[i].addr, VECS[i].data);
        OP_PULSE: pulse(int'(VECS[i].data));
        default:  out_chk(int'(VECS[i].req), VECS[i].data);
      endcase
    end

    // R9: a clear and an enabled rise on line 255 in the same cycle; the set wins
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 32'h0000_431C; bus_wdata = 32'h8000_0000;
    irq_in[255] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_in[255] = 1'b0;
    read_chk(9, 32'h0000_431C, 32'h8000_0000);
    bus_write(32'h0000_431C, 32'h8000_0000);          // R8 plain clear
    read_chk(8, 32'h0000_431C, 32'h0000_0000);

    // R3: disabled line 70 rises in the same cycle that its enable is written
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 32'h0000_0108; bus_wdata = 32'h0000_0040;
    irq_in[70] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_in[70] = 1'b0;
    read_chk(3, 32'h0000_4008, 32'h0000_0040);
    out_chk(3, 32'h0000_0001);                          // core0, group2 pin0
    // R2: no pending state may remain, so an enable toggle delivers nothing
    bus_write(32'h0000_4008, 32'h0000_0040);
    bus_write(32'h0000_0108, 32'h0000_0000);
    bus_write(32'h0000_0108, 32'h0000_0040);
    read_chk(2, 32'h0000_4008, 32'h0000_0000);

    // R11: reset in the middle of activity
    pulse(70);
    out_chk(11, 32'h0000_0001);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(11, "irq_out in reset", irq_out, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk(11, 32'h0000_0108, 32'h0000_0000);
    read_chk(11, 32'h0000_0404, 32'h0000_0000);
    read_chk(11, 32'h0000_08FC, 32'h0000_0000);
    read_chk(11, 32'h0000_4008, 32'h0000_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule